// File: doc/BRIEF.md
# Serial Trim Word Core With Stored Copy

This block is the digital heart of a trimmable analog cell. A host sends an 11-bit control word over two asynchronous wires, a serial clock and a serial data line. Both wires are brought into the system clock domain through two-flop synchronizers. Each synchronized rising edge of the serial clock shifts one data bit into the word. The block also keeps a persistent copy of the word, modelled here as a register that resets to zero.

The synchronized level of the serial clock also picks the mode. While it is high, the live 10-bit trim code comes from the shift register. While it is low, the trim code comes from the stored copy. A one-cycle programming strobe writes the stored copy from the inverted shift-register contents. The inverted low bit picks the write style: either the whole word is overwritten, or the selected bits are OR-ed in.

For readback, the host loads a word that is all ones except for one zero at the bit it wants to query. The verify output then shows that stored bit. There is no stream traffic in this block, so every pin is a plain level or strobe and nothing waits on back-pressure.

Top module: `trim_nvm_core`

## Requirements
- R1: After reset the stored word is 0. With the serial clock low, the trim code is 0 and verify_valid is 0.
- R2: On each synchronized rising edge of the serial clock, the data bit enters bit 10 and the rest of the word moves one place toward bit 0. The first of 11 bits sent ends in bit 0. Bits 10:9 are coarse group A, bits 8:6 are coarse group B, bits 5:1 are the fine group, and bit 0 is the mode/check bit.
- R3: While the synchronized serial clock is high, trim_code_o equals shift-register bits 10:1. While it is low, trim_code_o equals stored bits 10:1.
- R4: Bit 0 of the shift register has no effect on trim_code_o.
- R5: A twelfth rising edge shifts the word again: the new bit enters bit 10 and every old bit moves down by one place.
- R6: A strobe while the serial clock is high, with shift-register bit 0 equal to 0, overwrites the stored word with the bitwise inverse of the shift register. This style can clear bits as well as set them.
- R7: A strobe while the serial clock is high, with shift-register bit 0 equal to 1, ORs the inverse of the shift register into the stored word. Stored bits never go from 1 to 0 in this style.
- R8: A strobe while the synchronized serial clock is low leaves the stored word unchanged.
- R9: Verify_valid is 1 when the serial clock is high and the shift register holds exactly one zero. In that case, a zero at position k≥1 makes verify_o equal stored bit k, and a zero at position 0 makes verify_o equal 1.
- R10: With no zeros, with two or more zeros, or with the serial clock low, verify_valid_o and verify_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Asynchronous serial clock; its level also selects the mode |
| ser_dat_i | input | 1 | Asynchronous serial data |
| prog_strobe_i | input | 1 | One-cycle programming strobe, synchronous to clk |
| trim_code_o | output | 10 | Effective trim code |
| verify_o | output | 1 | Stored bit selected for readback |
| verify_valid_o | output | 1 | The readback pattern is well formed |

## Verification
A serial-line change reaches the outputs after the second clk edge. The third clk edge captures a shifted bit. The trim, mode and verify outputs follow combinationally from the registers, so they are settled one cycle after that. A strobe updates the stored word at the next clk edge. The bench waits four system cycles after each serial-line change and two after each strobe. It then samples on the falling edge of clk, well past every one of those latencies. Stored contents are read back either through the trim code with the serial clock low, or through the readback pattern.

// File: rtl/trim_pkg.sv
package trim_pkg;
  parameter int WORD_W = 11;
  parameter int SYNC_STAGES = 2;
  localparam int CODE_W = WORD_W - 1;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int W = 2,
  parameter int STAGES = trim_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/trim_shift.sv
module trim_shift
  import trim_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sdat_s,
  output logic [W-1:0] shreg_o
);
  logic sclk_prev_q;
  logic rise;
  logic [W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;

  assign rise = sclk_s & ~sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    shreg_q <= '0;
    else if (rise) shreg_q <= {sdat_s, shreg_q[W-1:1]};

  assign shreg_o = shreg_q;

  // R2 / R5: a detected edge moves the word down and inserts at the top
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> shreg_q == {$past(sdat_s), $past(shreg_q[W-1:1])});
  a_r5_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(shreg_q));
endmodule

// File: rtl/trim_store.sv
module trim_store
  import trim_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic         sclk_s,
  input  logic [W-1:0] shreg_i,
  output logic [W-1:0] stored_o
);
  typedef enum logic [1:0] {WR_NONE, WR_BULK, WR_OR} wr_kind_e;

  logic [W-1:0] inv_word;
  logic [W-1:0] stored_q;
  wr_kind_e     kind;

  assign inv_word = ~shreg_i;

  always_comb begin
    kind = WR_NONE;
    if (strobe_i && sclk_s) kind = inv_word[0] ? WR_BULK : WR_OR;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stored_q <= '0;
    else begin
      case (kind)
        WR_BULK: stored_q <= inv_word;
        WR_OR:   stored_q <= stored_q | inv_word;
        default: stored_q <= stored_q;
      endcase
    end

  assign stored_o = stored_q;

  a_r6_bulk_write: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && sclk_s && !shreg_i[0]) |=> stored_q == ~$past(shreg_i));
  a_r7_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && sclk_s && shreg_i[0]) |=> (stored_q & $past(stored_q)) == $past(stored_q));
  a_r8_ignored_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_i && sclk_s) |=> $stable(stored_q));
endmodule

// File: rtl/trim_readback.sv
module trim_readback
  import trim_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic [W-1:0] shreg_i,
  input  logic [W-1:0] stored_i,
  output logic         verify_o,
  output logic         valid_o
);
  logic [W-1:0] zero_mask;
  logic [W-1:0] view;

  assign zero_mask = ~shreg_i;
  assign view      = stored_i | W'(1);
  assign valid_o   = sclk_s && ($countones(zero_mask) == 1);
  assign verify_o  = valid_o && |(zero_mask & view);

  a_r10_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !verify_o);
  a_r9_check_bit_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_s && shreg_i == {{(W-1){1'b1}}, 1'b0}) |-> (valid_o && verify_o));
endmodule

// File: rtl/trim_nvm_core.sv
module trim_nvm_core
  import trim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              prog_strobe_i,
  output logic [CODE_W-1:0] trim_code_o,
  output logic              verify_o,
  output logic              verify_valid_o
);
  logic [1:0]  sync_lines;
  logic        sclk_s;
  logic        sdat_s;
  word_t       shreg;
  word_t       stored;

  trim_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_clk_i, ser_dat_i}),
    .sync_o  (sync_lines)
  );
  assign sclk_s = sync_lines[1];
  assign sdat_s = sync_lines[0];

  trim_shift #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sclk_s),
    .sdat_s  (sdat_s),
    .shreg_o (shreg)
  );

  trim_store #(.W(WORD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (prog_strobe_i),
    .sclk_s   (sclk_s),
    .shreg_i  (shreg),
    .stored_o (stored)
  );

  trim_readback #(.W(WORD_W)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .shreg_i  (shreg),
    .stored_i (stored),
    .verify_o (verify_o),
    .valid_o  (verify_valid_o)
  );

  assign trim_code_o = sclk_s ? shreg[WORD_W-1:1] : stored[WORD_W-1:1];

  a_r3_memory_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_s |-> trim_code_o == stored[WORD_W-1:1]);
  a_r3_shift_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_s |-> trim_code_o == shreg[WORD_W-1:1]);
endmodule

// File: tb/sim_trim_nvm_core.sv
module sim_trim_nvm_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       strobe = 1'b0;
  logic [9:0] trim;
  logic       ver;
  logic       ver_ok;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [10:0] TGT  = 11'b00010000101;
  localparam logic [10:0] TGT2 = 11'b00010100101;

  always #2.5 clk = ~clk;

  trim_nvm_core u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .prog_strobe_i(strobe), .trim_code_o(trim), .verify_o(ver),
    .verify_valid_o(ver_ok)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_bit(input logic d);
    ser_clk = 1'b0; waitn(4);
    ser_dat = d;    waitn(1);
    ser_clk = 1'b1; waitn(4);
  endtask

  task automatic send_word(input logic [10:0] w);
    for (int i = 0; i < 11; i++) edge_bit(w[i]);
  endtask

  task automatic pulse;
    @(negedge clk) strobe = 1'b1;
    @(negedge clk) strobe = 1'b0;
    waitn(2);
  endtask

  task automatic clk_low;
    ser_clk = 1'b0; waitn(4);
  endtask

  task automatic t_reset;
    check("R1 trim after reset", trim, 0);
    check("R1 verify_valid after reset", ver_ok, 0);
  endtask

  task automatic t_shift;
    logic [10:0] w;
    w = 11'b01011101111;
    send_word(w);
    check("R2 R3 shifted code", trim, int'(w[10:1]));
    send_word(w ^ 11'b1);
    check("R4 check bit ignored", trim, int'(w[10:1]));
    edge_bit(1'b1);
    check("R5 extra edge shifts", trim, int'({1'b1, w[10:2]}));
    clk_low();
    check("R3 memory mode shows stored 0", trim, 0);
  endtask

  task automatic t_bulk;
    send_word(~TGT);
    pulse();
    clk_low();
    check("R6 bulk write", trim, int'(TGT[10:1]));
  endtask

  task automatic t_low_strobe;
    send_word(11'b0);
    clk_low();
    pulse();
    check("R8 strobe with clock low ignored", trim, int'(TGT[10:1]));
  endtask

  task automatic t_single;
    send_word(~(11'b1 << 5));
    pulse();
    clk_low();
    check("R7 single-bit OR", trim, int'(TGT2[10:1]));
    send_word(~(11'b1 << 2));
    pulse();
    clk_low();
    check("R7 already set bit unchanged", trim, int'(TGT2[10:1]));
  endtask

  task automatic t_verify;
    for (int k = 1; k < 11; k++) begin
      send_word(~(11'b1 << k));
      check("R9 verify_valid", ver_ok, 1);
      check("R9 verify bit", ver, int'(TGT2[k]));
    end
    send_word(11'b11111111110);
    check("R9 check bit reads 1", ver, 1);
  endtask

  task automatic t_invalid;
    send_word(11'b11111111111);
    check("R10 no zero valid", ver_ok, 0);
    check("R10 no zero verify", ver, 0);
    send_word(11'b11111011011);
    check("R10 two zeros valid", ver_ok, 0);
    check("R10 two zeros verify", ver, 0);
    send_word(~(11'b1 << 2));
    clk_low();
    check("R10 clock low valid", ver_ok, 0);
    check("R10 clock low verify", ver, 0);
  endtask

  task automatic t_erase;
    send_word(11'b11111111110);
    pulse();
    clk_low();
    check("R6 erase clears stored code", trim, 0);
  endtask

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(3);
    t_reset();
    t_shift();
    t_bulk();
    t_low_strobe();
    t_single();
    t_verify();
    t_invalid();
    t_erase();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule